// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two signed two's-complement operands over several clock cycles. It uses radix-2 Booth recoding and needs no conversion to sign and magnitude. A caller presents the multiplicand and multiplier and pulses `start` while the block is idle. The block captures both operands. It then spends exactly `N` cycles examining the multiplier. Each cycle it looks at one bit together with the bit just below it, starting from the bottom. A zero is assumed below bit 0. Depending on that pair, the block adds the multiplicand into an accumulator, subtracts it, or leaves the accumulator alone. After that it shifts the combined accumulator and multiplier register right by one place and keeps the sign.

A run of ones in the multiplier therefore costs one subtraction where the run begins and one addition where it ends. The accumulator is one bit wider than the operands, so negating the most negative multiplicand cannot wrap. When the last step is finished, `done` is high for a single cycle. The `2N`-bit product stays on `product` until the next operation is accepted.

The controller has three states:
- `ST_IDLE` waits. It moves to `ST_RUN` on `start` (transition *accept*).
- `ST_RUN` performs one recode-and-shift step per cycle. It moves to `ST_DONE` after its `N`th step (transition *finish*).
- `ST_DONE` raises `done` and always returns to `ST_IDLE` (transition *release*).

Top module: `booth_mult`

## Requirements
- R1: After reset the block is in `ST_IDLE` with `busy`=0, `done`=0 and `product`=0.
- R2: A `start` sampled high in `ST_IDLE` captures `mcand` and `mplier`, and `busy` is 1 from the next cycle until `done` is raised.
- R3: Recoding starts with the pair (mplier[0], 0), because an implicit zero is placed below bit 0. Odd multipliers such as 1 therefore give exact products.
- R4: The pair (current, previous) = (0,1) adds the multiplicand at that bit weight.
- R5: The pair (1,0) subtracts the multiplicand at that bit weight. The pairs (0,0) and (1,1) change nothing before the shift, so an all-ones run costs one subtract and one add.
- R6: Exactly `N` steps are performed. `done` is high for exactly one cycle, in the `N`+1th cycle after the cycle in which `start` was accepted.
- R7: `product` equals the signed product of the two operands for every combination of signs, including the most negative value times itself.
- R8: Each step shifts the accumulator right arithmetically, so its top two bits are equal after every step.
- R9: `start` is ignored while `busy` is 1. The captured operands stay unchanged and the product of the first operands is delivered.
- R10: After `done`, `product` holds its value in `ST_IDLE` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Requests a multiplication; acted on only in `ST_IDLE` |
| mcand | input | N | Signed multiplicand |
| mplier | input | N | Signed multiplier |
| busy | output | 1 | High while recoding steps are in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2N | Signed product, held after `done` |

## Verification
The assertions assume that `start` and the operands change only away from the active clock edge, and that `start` may arrive in any state. The stimulus therefore drives inputs on the falling edge. It deliberately pulses `start` during `ST_RUN` with different operands, to show that the captured operands stay frozen. The assertions take no position on operand values, because every pattern of two's-complement bits is legal. The stimulus covers the four sign combinations, the extreme values, zero and all-ones multipliers, and alternating bit patterns that force an add or subtract on every step.

// File: rtl/booth_pkg.sv
package booth_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } booth_state_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_t;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic      cur_bit,
    input  logic      prev_bit,
    output booth_op_t op
);
    // Pair (current, previous): 01 adds, 10 subtracts, 00/11 idle (R4, R5)
    always_comb begin
        unique case ({cur_bit, prev_bit})
            2'b01:   op = OP_ADD;
            2'b10:   op = OP_SUB;
            default: op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int W = 9
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] addend,
    input  booth_op_t    op,
    output logic [W-1:0] result
);
    always_comb begin
        unique case (op)
            OP_ADD:  result = acc + addend;
            OP_SUB:  result = acc - addend;
            default: result = acc;
        endcase
    end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    output booth_state_t state,
    output logic         load,
    output logic         step,
    output logic         busy,
    output logic         done
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    booth_state_t nxt;
    logic [CW-1:0] cnt;
    logic          last;

    assign last = (cnt == LAST);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_RUN;
            ST_RUN:  if (last)  nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_RUN) cnt <= cnt + 1'b1;
            else                 cnt <= '0;
        end
    end

    always_comb begin
        load = (state == ST_IDLE) && start;
        step = (state == ST_RUN);
        busy = (state == ST_RUN);
        done = (state == ST_DONE);
    end

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state) == ST_RUN);
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !last) |=> (state == ST_RUN && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/booth_mult.sv
module booth_mult
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] product
);
    localparam int AW = N + 1;

    booth_state_t   state;
    booth_op_t      op;
    logic           load, step;
    logic [AW-1:0]  acc, m_reg, sum;
    logic [N-1:0]   q_reg;
    logic           q_prev;

    booth_ctrl #(.N(N)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .state(state),
        .load(load), .step(step), .busy(busy), .done(done)
    );

    booth_recode recode_i (.cur_bit(q_reg[0]), .prev_bit(q_prev), .op(op));

    booth_addsub #(.W(AW)) addsub_i (
        .acc(acc), .addend(m_reg), .op(op), .result(sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc    <= '0;
            m_reg  <= '0;
            q_reg  <= '0;
            q_prev <= 1'b0;
        end else if (load) begin
            acc    <= '0;
            m_reg  <= {mcand[N-1], mcand};
            q_reg  <= mplier;
            q_prev <= 1'b0;                       // implicit zero (R3)
        end else if (step) begin
            acc    <= {sum[AW-1], sum[AW-1:1]};   // arithmetic shift (R8)
            q_reg  <= {sum[0], q_reg[N-1:1]};
            q_prev <= q_reg[0];
        end
    end

    assign product = {acc[N-1:0], q_reg};

    assert_shift_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> acc[AW-1] == acc[AW-2]);
    assert_idle_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && q_reg[0] == q_prev) |=> acc == {$past(acc[AW-1]), $past(acc[AW-1:1])});
    assert_operand_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> $stable(m_reg));
    assert_first_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!q_prev && acc == '0));
endmodule

// File: tb/booth_mult_tb_top.sv
`timescale 1ns/1ps
module booth_mult_tb_top;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N-1:0]   mcand = '0;
    logic [N-1:0]   mplier = '0;
    logic           busy, done;
    logic [2*N-1:0] product;

    int     n_checks = 0;
    int     n_fail = 0;
    int     cycles = 0;
    string  cur_req = "R1";

    // behavioural reference
    int     ph = 0;
    int     cnt = 0;
    longint m_prod = 0;

    always #2 clk = ~clk;

    booth_mult #(.N(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
        .mplier(mplier), .busy(busy), .done(done), .product(product)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; cnt = 0; m_prod = 0;
        end else begin
            case (ph)
                0: if (start) begin
                       m_prod = longint'($signed(mcand)) * longint'($signed(mplier));
                       ph = 1; cnt = 0;
                   end
                1: begin
                       cnt++;
                       if (cnt == N) ph = 2;
                   end
                default: ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            n_checks++;
            if (busy !== (ph == 1)) begin
                n_fail++;
                $display("FAIL R2: busy actual %0b expected %0b", busy, ph == 1);
            end
            n_checks++;
            if (done !== (ph == 2)) begin
                n_fail++;
                $display("FAIL R6: done actual %0b expected %0b", done, ph == 2);
            end
            if (ph != 1) begin
                n_checks++;
                if (product !== m_prod[2*N-1:0]) begin
                    n_fail++;
                    $display("FAIL %s: product actual %0d expected %0d",
                             cur_req, $signed(product), m_prod);
                end
            end
        end
    end

    task automatic mul(input int a, input int b, input string req);
        @(negedge clk);
        cur_req = req;
        mcand = N'(a); mplier = N'(b); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (N + 2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);              // R1 reset state checked
        mul(7, 3, "R7");
        mul(7, -3, "R7");
        mul(-7, 3, "R7");
        mul(-7, -3, "R7");
        mul(20, 30, "R5");                       // runs of ones
        mul(1, 1, "R3");                         // implicit zero below bit 0
        mul(-5, 1, "R3");
        mul(13, 8'h55, "R4");                    // alternating pairs add/sub
        mul(-9, 8'hAA, "R4");
        mul(37, -1, "R5");                       // one subtract only
        mul(-128, -128, "R8");                   // most negative squared
        mul(-128, 127, "R8");
        mul(127, 127, "R7");
        mul(0, -77, "R7");
        // R9: start pulsed mid-run with other operands
        @(negedge clk);
        cur_req = "R9";
        mcand = 8'd11; mplier = 8'd12; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        mcand = 8'd99; mplier = -8'sd50; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (N + 2) @(negedge clk);
        // R10: hold in idle
        cur_req = "R10";
        repeat (6) @(negedge clk);
        finish_run();
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        wait (cycles > 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: cycles actual %0d expected below 5000", cycles);
        finish_run();
    end
endmodule